// File: doc/BRIEF.md
# RDS Group Synchronization Controller

This block sits behind a syndrome checker on a radio data stream made of 26-bit blocks. On every received bit the checker reports which offset class the last 26 bits carry (A, B, C, C', D, E, F or none) and whether the block content is all zeros. The controller hunts for two offsets that form a legal succession at the right distance and then declares block synchronization. While synchronized it looks only at 26-bit boundaries, reports a block number for every block (the predicted one when no offset is seen), and decides when downstream output may start. A run of missed offsets returns it to hunting.

Mixed streams are accepted: four-block groups (A, B, C or C', D) may alternate with runs of E blocks of any length without losing sync. The control is one finite-state machine with four states. `ST_HUNT` waits for any recognised offset, which moves it to `ST_ARMED` (candidate held). From `ST_ARMED` a legal pair declares sync and moves to `ST_GATED`. A new detection at another distance replaces the candidate and stays in `ST_ARMED`. Expiry of the candidate window returns to `ST_HUNT`. `ST_GATED` (synced, output held back) moves to `ST_STREAM` (synced, output running) on the block where output may begin. Both synced states return to `ST_HUNT` on the fifth consecutive missed offset.

Top module: `rds_sync_ctrl`

## Requirements
- R1: A synchronous active-low reset sets the block to hunting, with `in_sync`, `out_en`, `blk_tick`, `offset_e` and `blk_num` all 0.
- R2: Offset codes on `ofs_code` are 0 none, 1 A, 2 B, 3 C, 4 C', 5 D, 6 E, 7 F. Code 7 is never treated as a recognised offset. A bit with `zero_blk` high is classified as E whatever `ofs_code` says.
- R3: While hunting, a recognised offset followed exactly 26 strobed bits later by a legal successor declares sync. The legal successions are A to B, B to C, B to C', C to D, C' to D, D to A, D to E, E to E and E to A. `in_sync` is 1 after the clock edge that takes the second offset.
- R4: Any other succession (for example A to C, B to E, E to B) does not declare sync.
- R5: A detection at a distance other than 26 bits does not declare sync. It replaces the held candidate.
- R6: An E candidate also declares sync when a second E arrives 52 bits later. A non-E candidate expires after 26 bits without a detection.
- R7: After sync on A or E, `out_en` rises with the next block. After sync on B, C, C' or D, `out_en` rises with the first following block numbered as A or E. `out_en` is never 1 without `in_sync`.
- R8: While synced, `blk_tick` pulses for one cycle per 26-bit boundary that keeps sync. `blk_num` reports 00 for A, 01 for B, 10 for C or C', 11 for D. An E block reports 00 with `offset_e` at 1.
- R9: A synced boundary without a legal detected offset reports the block number that the correct order predicts.
- R10: Four consecutive missed boundaries keep sync. The fifth clears `in_sync` and `out_en` and returns to hunting. A legal offset resets the miss run.
- R11: `grp_ver` becomes 0 on a detected third block with C and 1 with C'. It does not change at the first or second block, nor on a predicted third block.
- R12: While synced, detections between boundaries have no effect on any output.
- R13: Runs of E blocks of any length keep sync, and E followed by A continues the group order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_strobe | input | 1 | One pulse per received data bit |
| ofs_code | input | 3 | Offset class of the 26 bits ending at this bit |
| zero_blk | input | 1 | The 26 bits ending at this bit are all zero |
| in_sync | output | 1 | Block synchronization held |
| out_en | output | 1 | Block output permitted |
| blk_tick | output | 1 | One-cycle pulse at each synced block boundary |
| blk_num | output | 2 | Block number of the block just completed |
| offset_e | output | 1 | Block just completed is an E block |
| grp_ver | output | 1 | Group version taken from the third block |

## Verification
Two events can land on the same boundary: the fifth missed offset that ends sync, and the boundary at which gated output would have started. The bench ends a stream with five empty blocks right after a legal one. At the fourth miss it expects the predicted number with output still running; at the fifth it expects `in_sync`, `out_en` and `blk_tick` all low together. A second collision occurs at the sync instant itself, where the pair decision and the start rule for output meet. Sweeping every ordered pair of offset codes checks the pair decision, and separate runs of syncs on A, on B and on E check the start rule block by block.

// File: rtl/rds_sync_pkg.sv
package rds_sync_pkg;

    typedef enum logic [2:0] {
        OFS_NONE = 3'd0,
        OFS_A    = 3'd1,
        OFS_B    = 3'd2,
        OFS_C    = 3'd3,
        OFS_CP   = 3'd4,
        OFS_D    = 3'd5,
        OFS_E    = 3'd6,
        OFS_F    = 3'd7
    } ofs_t;

    typedef enum logic [1:0] {
        ST_HUNT   = 2'd0,
        ST_ARMED  = 2'd1,
        ST_GATED  = 2'd2,
        ST_STREAM = 2'd3
    } sync_st_t;

    // Position of an offset inside a group; E blocks report the first slot.
    function automatic logic [1:0] ofs_blk_num(input ofs_t o);
        logic [1:0] n;
        case (o)
            OFS_B:          n = 2'b01;
            OFS_C, OFS_CP:  n = 2'b10;
            OFS_D:          n = 2'b11;
            default:        n = 2'b00;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/rds_ofs_filter.sv
module rds_ofs_filter
    import rds_sync_pkg::*;
(
    input  logic [2:0] raw_code,
    input  logic       all_zero,
    output ofs_t       clean_ofs
);
    always_comb begin
        if (all_zero) begin
            clean_ofs = OFS_E;
        end else if (ofs_t'(raw_code) == OFS_F) begin
            // F is never accepted as an offset
            clean_ofs = OFS_NONE;
        end else begin
            clean_ofs = ofs_t'(raw_code);
        end
    end
endmodule

// File: rtl/rds_succ_table.sv
module rds_succ_table
    import rds_sync_pkg::*;
(
    input  ofs_t prev_ofs,
    input  ofs_t cur_ofs,
    output logic legal,
    output ofs_t guess
);
    always_comb begin
        legal = 1'b0;
        guess = OFS_NONE;
        case (prev_ofs)
            OFS_A: begin
                legal = (cur_ofs == OFS_B);
                guess = OFS_B;
            end
            OFS_B: begin
                legal = (cur_ofs == OFS_C) || (cur_ofs == OFS_CP);
                guess = OFS_C;
            end
            OFS_C, OFS_CP: begin
                legal = (cur_ofs == OFS_D);
                guess = OFS_D;
            end
            OFS_D: begin
                legal = (cur_ofs == OFS_A) || (cur_ofs == OFS_E);
                guess = OFS_A;
            end
            OFS_E: begin
                legal = (cur_ofs == OFS_E) || (cur_ofs == OFS_A);
                guess = OFS_E;
            end
            default: begin
                legal = 1'b0;
                guess = OFS_NONE;
            end
        endcase
    end
endmodule

// File: rtl/rds_bit_count.sv
module rds_bit_count #(
    parameter int MAX_CNT = 52,
    localparam int CW = $clog2(MAX_CNT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          step,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] TOP = CW'(MAX_CNT);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (step && (cnt != TOP)) begin
            cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/rds_sync_ctrl.sv
module rds_sync_ctrl
    import rds_sync_pkg::*;
#(
    parameter int BLK_BITS   = 26,
    parameter int PULL_LIMIT = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_strobe,
    input  logic [2:0] ofs_code,
    input  logic       zero_blk,
    output logic       in_sync,
    output logic       out_en,
    output logic       blk_tick,
    output logic [1:0] blk_num,
    output logic       offset_e,
    output logic       grp_ver
);
    localparam int SPAN2 = 2 * BLK_BITS;
    localparam int CW    = $clog2(SPAN2 + 1);
    localparam int MW    = $clog2(PULL_LIMIT + 1);
    localparam logic [CW-1:0] ONE_BLK  = CW'(BLK_BITS);
    localparam logic [CW-1:0] TWO_BLK  = CW'(SPAN2);
    localparam logic [CW-1:0] LAST_BIT = CW'(BLK_BITS - 1);
    localparam logic [MW-1:0] MISS_TOP = MW'(PULL_LIMIT - 1);

    sync_st_t      st, st_n;
    ofs_t          ref_q, ref_n;
    logic [MW-1:0] miss_q, miss_n;
    logic          go_q, go_n;

    ofs_t          clean;
    logic          legal;
    ofs_t          guess;
    logic [CW-1:0] cnt;
    logic [CW-1:0] step_n;
    logic          cnt_clr, cnt_step;

    logic          sync_n, en_n, tick_n, ofse_n, ver_n;
    logic [1:0]    num_n;

    logic          detected, hit_one, hit_two, pair_ok, expire, at_edge;
    logic          good, miss_last;
    ofs_t          res;

    rds_ofs_filter u_filter (
        .raw_code  (ofs_code),
        .all_zero  (zero_blk),
        .clean_ofs (clean)
    );

    rds_succ_table u_succ (
        .prev_ofs (ref_q),
        .cur_ofs  (clean),
        .legal    (legal),
        .guess    (guess)
    );

    rds_bit_count #(.MAX_CNT(SPAN2)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .step  (cnt_step),
        .cnt   (cnt)
    );

    // Distance and boundary decode
    always_comb begin
        step_n    = cnt + CW'(1);
        detected  = (clean != OFS_NONE);
        hit_one   = (step_n == ONE_BLK);
        hit_two   = (step_n == TWO_BLK);
        pair_ok   = detected && ((hit_one && legal) ||
                    (hit_two && (ref_q == OFS_E) && (clean == OFS_E)));
        expire    = (ref_q == OFS_E) ? hit_two : hit_one;
        at_edge   = (cnt == LAST_BIT);
        good      = detected && legal;
        res       = good ? clean : guess;
        miss_last = (miss_q == MISS_TOP);
    end

    // Next-state and next-output logic
    always_comb begin
        st_n     = st;
        ref_n    = ref_q;
        miss_n   = miss_q;
        go_n     = go_q;
        cnt_clr  = 1'b0;
        cnt_step = 1'b0;
        sync_n   = in_sync;
        en_n     = out_en;
        tick_n   = 1'b0;
        num_n    = blk_num;
        ofse_n   = offset_e;
        ver_n    = grp_ver;
        if (bit_strobe) begin
            unique case (st)
                ST_HUNT: begin
                    if (detected) begin
                        ref_n   = clean;
                        cnt_clr = 1'b1;
                        st_n    = ST_ARMED;
                    end
                end
                ST_ARMED: begin
                    if (pair_ok) begin
                        st_n    = ST_GATED;
                        ref_n   = clean;
                        cnt_clr = 1'b1;
                        miss_n  = '0;
                        go_n    = (clean == OFS_A) || (clean == OFS_E);
                        sync_n  = 1'b1;
                        num_n   = ofs_blk_num(clean);
                        ofse_n  = (clean == OFS_E);
                        if (clean == OFS_C)  ver_n = 1'b0;
                        if (clean == OFS_CP) ver_n = 1'b1;
                    end else if (detected) begin
                        ref_n   = clean;
                        cnt_clr = 1'b1;
                    end else if (expire) begin
                        st_n    = ST_HUNT;
                        ref_n   = OFS_NONE;
                        cnt_clr = 1'b1;
                    end else begin
                        cnt_step = 1'b1;
                    end
                end
                ST_GATED, ST_STREAM: begin
                    if (!at_edge) begin
                        cnt_step = 1'b1;
                    end else begin
                        cnt_clr = 1'b1;
                        if (!good && miss_last) begin
                            st_n   = ST_HUNT;
                            ref_n  = OFS_NONE;
                            miss_n = '0;
                            go_n   = 1'b0;
                            sync_n = 1'b0;
                            en_n   = 1'b0;
                            num_n  = 2'b00;
                            ofse_n = 1'b0;
                        end else begin
                            miss_n = good ? '0 : miss_q + MW'(1);
                            ref_n  = res;
                            tick_n = 1'b1;
                            num_n  = ofs_blk_num(res);
                            ofse_n = (res == OFS_E);
                            if (good && (clean == OFS_C))  ver_n = 1'b0;
                            if (good && (clean == OFS_CP)) ver_n = 1'b1;
                            if ((st == ST_GATED) &&
                                (go_q || (res == OFS_A) || (res == OFS_E))) begin
                                st_n = ST_STREAM;
                                en_n = 1'b1;
                            end
                        end
                    end
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_HUNT;
            ref_q  <= OFS_NONE;
            miss_q <= '0;
            go_q   <= 1'b0;
        end else begin
            st     <= st_n;
            ref_q  <= ref_n;
            miss_q <= miss_n;
            go_q   <= go_n;
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_sync  <= 1'b0;
            out_en   <= 1'b0;
            blk_tick <= 1'b0;
            blk_num  <= 2'b00;
            offset_e <= 1'b0;
            grp_ver  <= 1'b0;
        end else begin
            in_sync  <= sync_n;
            out_en   <= en_n;
            blk_tick <= tick_n;
            blk_num  <= num_n;
            offset_e <= ofse_n;
            grp_ver  <= ver_n;
        end
    end
endmodule

// File: rtl/rds_sync_ctrl_chk.sv
module rds_sync_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_strobe,
    input logic       in_sync,
    input logic       out_en,
    input logic       blk_tick,
    input logic [1:0] blk_num,
    input logic       offset_e
);
    // R1
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!in_sync && !out_en && !blk_tick && !offset_e));

    // R7
    a_r7_enable_needs_sync: assert property (@(posedge clk) disable iff (!rst_n)
        out_en |-> in_sync);

    // R8
    a_r8_e_in_first_slot: assert property (@(posedge clk) disable iff (!rst_n)
        offset_e |-> (blk_num == 2'b00));

    // R8
    a_r8_tick_only_synced: assert property (@(posedge clk) disable iff (!rst_n)
        blk_tick |-> in_sync);

    // R10
    a_r10_loss_stops_output: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_sync) |-> (!out_en && !blk_tick));

    // R12
    a_r12_tick_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        blk_tick |-> $past(bit_strobe));

    // R12
    a_r12_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bit_strobe) |-> ($stable(in_sync) && $stable(blk_num) && $stable(out_en)));
endmodule

bind rds_sync_ctrl rds_sync_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_strobe (bit_strobe),
    .in_sync    (in_sync),
    .out_en     (out_en),
    .blk_tick   (blk_tick),
    .blk_num    (blk_num),
    .offset_e   (offset_e)
);

// File: tb/rds_sync_ctrl_bench.sv
`timescale 1ns/1ps
module rds_sync_ctrl_bench;
    localparam int NB = 26;
    localparam logic [2:0] C_NONE = 3'd0, C_A = 3'd1, C_B = 3'd2, C_C = 3'd3,
                           C_CP = 3'd4, C_D = 3'd5, C_E = 3'd6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_strobe = 1'b0;
    logic [2:0] ofs_code = 3'd0;
    logic zero_blk = 1'b0;
    logic in_sync, out_en, blk_tick, offset_e, grp_ver;
    logic [1:0] blk_num;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    rds_sync_ctrl u_rds_sync_ctrl (
        .clk(clk), .rst_n(rst_n), .bit_strobe(bit_strobe), .ofs_code(ofs_code),
        .zero_blk(zero_blk), .in_sync(in_sync), .out_en(out_en), .blk_tick(blk_tick),
        .blk_num(blk_num), .offset_e(offset_e), .grp_ver(grp_ver)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bit_strobe = 1'b0; ofs_code = C_NONE; zero_blk = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic one_bit(input logic [2:0] c, input logic z);
        @(negedge clk);
        bit_strobe = 1'b1; ofs_code = c; zero_blk = z;
        @(posedge clk);
        #1;
        bit_strobe = 1'b0; ofs_code = C_NONE; zero_blk = 1'b0;
    endtask

    // n bits: n-1 empty bits then the code on the last one
    task automatic blk_n(input logic [2:0] c, input int n);
        for (int i = 0; i < n - 1; i++) one_bit(C_NONE, 1'b0);
        one_bit(c, 1'b0);
    endtask

    task automatic blk(input logic [2:0] c);
        blk_n(c, NB);
    endtask

    function automatic bit ref_legal(input logic [2:0] p, input logic [2:0] q);
        case (p)
            C_A:       return q == C_B;
            C_B:       return (q == C_C) || (q == C_CP);
            C_C, C_CP: return q == C_D;
            C_D:       return (q == C_A) || (q == C_E);
            C_E:       return (q == C_E) || (q == C_A);
            default:   return 1'b0;
        endcase
    endfunction

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_fail++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
                $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
                $finish;
            end
        end
    end

    initial begin
        do_reset();
        // R1: reset state
        check("R1 in_sync", in_sync, 0);
        check("R1 out_en", out_en, 0);
        check("R1 blk_tick", blk_tick, 0);
        check("R1 blk_num", blk_num, 0);
        check("R1 offset_e", offset_e, 0);

        // R2 R3 R4: sweep over every ordered pair of codes 1..7
        for (int p = 1; p < 8; p++) begin
            for (int q = 1; q < 8; q++) begin
                do_reset();
                blk(3'(p));
                blk(3'(q));
                check($sformatf("R3/R4/R2 pair %0d-%0d", p, q), in_sync,
                      8'(ref_legal(3'(p), 3'(q))));
            end
        end

        // R2: all-zero block taken as E
        do_reset();
        for (int i = 0; i < NB - 1; i++) one_bit(C_NONE, 1'b0);
        one_bit(C_B, 1'b1);
        blk(C_E);
        check("R2 zero as E sync", in_sync, 1);
        check("R2 zero as E flag", offset_e, 1);

        // R5: wrong distance replaces candidate
        do_reset();
        blk(C_D);
        blk_n(C_A, NB - 1);
        check("R5 25-bit no sync", in_sync, 0);
        blk(C_B);
        check("R5 replaced candidate syncs", in_sync, 1);

        // R6: E two of three, non-E expires
        do_reset();
        blk(C_E); blk(C_NONE); blk(C_E);
        check("R6 E 52-bit sync", in_sync, 1);
        do_reset();
        blk(C_D); blk(C_NONE); blk(C_A);
        check("R6 non-E expires", in_sync, 0);

        // R7: sync on B, output waits for A
        do_reset();
        blk(C_A); blk(C_B);
        check("R7 sync on B", in_sync, 1);
        check("R7 gated at B", out_en, 0);
        check("R8 num B", blk_num, 1);
        blk(C_C);
        check("R7 gated at C", out_en, 0);
        blk(C_D);
        check("R7 gated at D", out_en, 0);
        blk(C_A);
        check("R7 starts at A", out_en, 1);
        check("R8 num A", blk_num, 0);

        // R7 R8 R11 R12 R9 R10: sync on A then a full stream
        do_reset();
        blk(C_D); blk(C_A);
        check("R7 sync on A", in_sync, 1);
        check("R7 gated on A", out_en, 0);
        check("R8 no tick at sync", blk_tick, 0);
        blk(C_B);
        check("R7 starts at B", out_en, 1);
        check("R8 tick", blk_tick, 1);
        check("R8 num B", blk_num, 1);
        blk(C_CP);
        check("R11 C' sets 1", grp_ver, 1);
        check("R8 num C'", blk_num, 2);
        blk(C_D);
        check("R8 num D", blk_num, 3);
        blk(C_A);
        check("R11 held at A", grp_ver, 1);
        blk(C_B);
        check("R11 held at B", grp_ver, 1);
        // R12: detection between boundaries
        for (int i = 0; i < 10; i++) one_bit(C_NONE, 1'b0);
        one_bit(C_A, 1'b0);
        check("R12 mid tick", blk_tick, 0);
        check("R12 mid num", blk_num, 1);
        check("R12 mid sync", in_sync, 1);
        blk_n(C_C, NB - 11);
        check("R11 C sets 0", grp_ver, 0);
        check("R8 num C", blk_num, 2);
        check("R12 boundary tick", blk_tick, 1);
        blk(C_D);
        // R9: predicted numbers across four misses
        for (int k = 0; k < 4; k++) begin
            blk(C_NONE);
            check("R9 predicted num", blk_num, 8'(k));
            check("R10 kept sync", in_sync, 1);
            check("R10 kept output", out_en, 1);
        end
        blk(C_A);
        check("R10 legal resets run", blk_num, 0);
        for (int k = 0; k < 4; k++) blk(C_NONE);
        check("R10 four misses keep", in_sync, 1);
        check("R9 predicted after A", blk_num, 0);
        blk(C_NONE);
        check("R10 fifth drops sync", in_sync, 0);
        check("R10 fifth drops out_en", out_en, 0);
        check("R10 no tick on loss", blk_tick, 0);

        // R13: long E run then A
        do_reset();
        blk(C_E); blk(C_E);
        check("R13 sync on E", in_sync, 1);
        check("R7 gated on E", out_en, 0);
        for (int k = 0; k < 7; k++) begin
            blk(C_E);
            check("R13 E run sync", in_sync, 1);
            check("R13 E run out_en", out_en, 1);
            check("R8 E flag", offset_e, 1);
            check("R8 E num", blk_num, 0);
        end
        blk(C_A);
        check("R13 E to A flag", offset_e, 0);
        check("R13 E to A num", blk_num, 0);
        blk(C_B);
        check("R13 continues B", blk_num, 1);
        check("R13 still synced", in_sync, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule